// File: doc/BRIEF.md
# Timer-Latch Short-Circuit Protector

This block guards a multi-channel switching regulator against sustained short circuits or overloads. Each of three channels presents a digital fault flag that an analog comparator has already resolved. Channels 1 and 3 flag a fault when their feedback sits too high, and channel 2 flags a fault when its feedback sits too low. While any qualified fault is present, the block counts carrier periods. Each period arrives as a one-cycle tick. If the fault is still present when the count reaches its terminal value, the block sets an off-latch that shuts down every output channel.

The terminal value is 2^SHORT_EXP periods when the range select is low and 2^LONG_EXP periods when it is high. The defaults are 16 and 17. A fault that disappears before the terminal value is reached restarts the timing from zero.

Soft start masks some faults:
- The channel 1 fault is ignored while the channel 1 soft-start level is below its threshold.
- The channel 2 fault is ignored while the channel 2 soft-start level is above its threshold.
- The channel 3 fault is never masked.

Once set, the off-latch stays set until one of two things happens. Either undervoltage lockout asserts, or the soft-start node of a channel that caused the trip is driven to its reset level.

Top module: `fault_timer_latch`

## Requirements
- R1: After synchronous reset, `shutdown` and `timing` are both 0.
- R2: While a qualified fault is present and the latch is clear, the period count advances by exactly one on each cycle with `period_tick`=1. `timing` is 1 exactly when the count is nonzero. Ticks without a qualified fault do not advance the count.
- R3: `shutdown` rises one cycle after the tick that completes 2^SHORT_EXP consecutive faulted periods when `range_long`=0, or 2^LONG_EXP faulted periods when `range_long`=1. No earlier tick sets it.
- R4: Any cycle with no qualified fault returns the count to zero, so a fault that comes back needs the full terminal number of periods again.
- R5: While `shutdown`=1, the count is held at zero (`timing`=0), and further ticks and fault changes leave `shutdown` at 1.
- R6: `flt_ch1_high` is ignored while `ss1_below_thr`=1. `flt_ch2_low` is ignored while `ss2_above_thr`=1. `flt_ch3_high` is never masked.
- R7: The latch records which qualified faults caused the trip. Channel 1 or channel 3 causes are released by `ss1_at_reset`=1, and a channel 2 cause is released by `ss2_at_reset`=1. The soft-start reset of a channel that did not cause the trip leaves `shutdown` at 1.
- R8: `uvlo`=1 clears the latch on the next edge and holds the count at zero while asserted.
- R9: If `range_long` falls during a count that already exceeds the short terminal value, the next qualified tick sets the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_tick | input | 1 | One-cycle pulse per carrier period |
| flt_ch1_high | input | 1 | Channel 1 feedback above its upper threshold |
| flt_ch2_low | input | 1 | Channel 2 feedback below its lower threshold |
| flt_ch3_high | input | 1 | Channel 3 feedback above its upper threshold |
| ss1_below_thr | input | 1 | Channel 1 soft-start level below its mask threshold |
| ss2_above_thr | input | 1 | Channel 2 soft-start level above its mask threshold |
| range_long | input | 1 | 0 selects 2^SHORT_EXP periods, 1 selects 2^LONG_EXP periods |
| ss1_at_reset | input | 1 | Channel 1 soft-start node forced to its reset level |
| ss2_at_reset | input | 1 | Channel 2 soft-start node forced to its reset level |
| uvlo | input | 1 | Undervoltage lockout active |
| shutdown | output | 1 | Off-latch set: all channels off |
| timing | output | 1 | Fault period count is nonzero |

## Verification
The assertions assume that every input is synchronous to `clk` and that `period_tick` is a single-cycle pulse. They also assume that fault and mask levels change only between clock edges. The bench drives all inputs on the falling edge. It separates ticks by an idle cycle and changes fault, mask and range inputs only in cycles without a tick. The bench uses exponents 3 and 4, so that both terminal values and every duration around them can be swept in full.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

    typedef struct packed {
        logic ch3;
        logic ch2;
        logic ch1;
    } chan_vec_t;

    // A trip is released when a causing channel's soft-start node is at reset.
    // Channel 3 has no soft-start node of its own and shares channel 1's.
    function automatic logic release_hit(chan_vec_t cause, logic ss1_rst, logic ss2_rst);
        return ((cause.ch1 | cause.ch3) & ss1_rst) | (cause.ch2 & ss2_rst);
    endfunction

endpackage

// File: rtl/ftl_qualify.sv
module ftl_qualify
    import ftl_pkg::*;
(
    input  logic      flt_ch1_high,
    input  logic      flt_ch2_low,
    input  logic      flt_ch3_high,
    input  logic      ss1_below_thr,
    input  logic      ss2_above_thr,
    output chan_vec_t qualified,
    output logic      any_fault
);
    always_comb begin
        qualified.ch1 = flt_ch1_high & ~ss1_below_thr;
        qualified.ch2 = flt_ch2_low  & ~ss2_above_thr;
        qualified.ch3 = flt_ch3_high;
        any_fault     = |qualified;
    end
endmodule

// File: rtl/ftl_period_timer.sv
module ftl_period_timer #(
    parameter int SHORT_EXP = 16,
    parameter int LONG_EXP  = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic active,
    input  logic tick,
    input  logic range_long,
    output logic hit,
    output logic nonzero
);
    localparam int CW = LONG_EXP;
    localparam logic [CW-1:0] LAST_SHORT = CW'((64'd1 << SHORT_EXP) - 64'd1);
    localparam logic [CW-1:0] LAST_LONG  = {CW{1'b1}};

    logic [CW-1:0] count_q;
    logic [CW-1:0] last_sel;

    always_comb begin
        last_sel = range_long ? LAST_LONG : LAST_SHORT;
        hit      = active & tick & ~hold & (count_q >= last_sel);
        nonzero  = (count_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || hold || !active) begin
            count_q <= '0;
        end else if (tick) begin
            if (hit) count_q <= '0;
            else     count_q <= count_q + 1'b1;
        end
    end

    assert_fault_gone_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !active |=> (count_q == '0));

    assert_hold_zero_R5: assert property (@(posedge clk) disable iff (rst)
        hold |=> (count_q == '0));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
        (active && tick && !hold && !hit) |=> (count_q == $past(count_q) + 1'b1));

    assert_no_tick_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (active && !tick && !hold) |=> $stable(count_q));
endmodule

// File: rtl/ftl_off_latch.sv
module ftl_off_latch
    import ftl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      trip,
    input  chan_vec_t trip_cause,
    input  logic      uvlo,
    input  logic      ss1_rst,
    input  logic      ss2_rst,
    output logic      latched
);
    chan_vec_t cause_q;
    logic      release_now;

    always_comb release_now = release_hit(cause_q, ss1_rst, ss2_rst);

    always_ff @(posedge clk) begin
        if (rst || uvlo) begin
            latched <= 1'b0;
            cause_q <= '0;
        end else if (latched) begin
            if (release_now) begin
                latched <= 1'b0;
                cause_q <= '0;
            end
        end else if (trip) begin
            latched <= 1'b1;
            cause_q <= trip_cause;
        end
    end

    assert_uvlo_clears_R8: assert property (@(posedge clk) disable iff (rst)
        uvlo |=> !latched);

    assert_trip_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (trip && !uvlo) |=> latched);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (latched && !uvlo && !ss1_rst && !ss2_rst) |=> latched);
endmodule

// File: rtl/fault_timer_latch.sv
module fault_timer_latch
    import ftl_pkg::*;
#(
    parameter int SHORT_EXP = 16,
    parameter int LONG_EXP  = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic period_tick,
    input  logic flt_ch1_high,
    input  logic flt_ch2_low,
    input  logic flt_ch3_high,
    input  logic ss1_below_thr,
    input  logic ss2_above_thr,
    input  logic range_long,
    input  logic ss1_at_reset,
    input  logic ss2_at_reset,
    input  logic uvlo,
    output logic shutdown,
    output logic timing
);
    chan_vec_t qual;
    logic      any_fault;
    logic      hold;
    logic      hit;

    ftl_qualify u_qual (
        .flt_ch1_high (flt_ch1_high),
        .flt_ch2_low  (flt_ch2_low),
        .flt_ch3_high (flt_ch3_high),
        .ss1_below_thr(ss1_below_thr),
        .ss2_above_thr(ss2_above_thr),
        .qualified    (qual),
        .any_fault    (any_fault)
    );

    always_comb hold = shutdown | uvlo;

    ftl_period_timer #(
        .SHORT_EXP(SHORT_EXP),
        .LONG_EXP (LONG_EXP)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .active    (any_fault),
        .tick      (period_tick),
        .range_long(range_long),
        .hit       (hit),
        .nonzero   (timing)
    );

    ftl_off_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .trip      (hit),
        .trip_cause(qual),
        .uvlo      (uvlo),
        .ss1_rst   (ss1_at_reset),
        .ss2_rst   (ss2_at_reset),
        .latched   (shutdown)
    );

    assert_rise_after_count_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown) |-> $past(timing));

    assert_latched_no_timing_R5: assert property (@(posedge clk) disable iff (rst)
        (shutdown && $past(shutdown)) |-> !timing);
endmodule

// File: tb/fault_timer_latch_test.sv
module fault_timer_latch_test;
    localparam int SE = 3;
    localparam int LE = 4;
    localparam int TS = 1 << SE;
    localparam int TL = 1 << LE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 0, f1 = 0, f2 = 0, f3 = 0, m1 = 0, m2 = 0, rl = 0, r1 = 0, r2 = 0, uv = 0;
    logic shutdown, timing;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fault_timer_latch #(.SHORT_EXP(SE), .LONG_EXP(LE)) uut (
        .clk(clk), .rst(rst), .period_tick(tick),
        .flt_ch1_high(f1), .flt_ch2_low(f2), .flt_ch3_high(f3),
        .ss1_below_thr(m1), .ss2_above_thr(m2), .range_long(rl),
        .ss1_at_reset(r1), .ss2_at_reset(r2), .uvlo(uv),
        .shutdown(shutdown), .timing(timing)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        {tick, f1, f2, f3, m1, m2, rl, r1, r2, uv} = '0;
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic pulse_rel(bit which);
        if (which) r2 = 1'b1; else r1 = 1'b1;
        @(negedge clk);
        r1 = 1'b0; r2 = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 shutdown", shutdown, 1'b0);
        chk("R1 timing", timing, 1'b0);

        // R3/R2 sweep over durations for both ranges
        for (int r = 0; r < 2; r++) begin
            for (int n = 1; n <= (r ? TL : TS) + 1; n++) begin
                do_reset();
                rl = r[0];
                f1 = 1'b1;
                ticks(n);
                chk("R3 terminal", shutdown, (n >= (r ? TL : TS)));
                chk("R2 timing", timing, (n < (r ? TL : TS)));
            end
        end

        // R2: ticks without fault do not count
        do_reset();
        ticks(5);
        chk("R2 no fault", timing, 1'b0);
        f1 = 1'b1;
        idle(4);
        chk("R2 no tick", timing, 1'b0);

        // R4: brief clear restarts count
        do_reset();
        f3 = 1'b1;
        ticks(TS - 1);
        chk("R4 pre", timing, 1'b1);
        f3 = 1'b0;
        idle(1);
        chk("R4 cleared", timing, 1'b0);
        f3 = 1'b1;
        ticks(TS - 1);
        chk("R4 restart short", shutdown, 1'b0);
        ticks(1);
        chk("R4 restart full", shutdown, 1'b1);

        // R5: latched state holds
        ticks(3);
        f3 = 1'b0;
        idle(2);
        chk("R5 hold", shutdown, 1'b1);
        chk("R5 count zero", timing, 1'b0);

        // R6: masks
        do_reset();
        m1 = 1'b1; f1 = 1'b1;
        ticks(TS + 2);
        chk("R6 ch1 masked", shutdown, 1'b0);
        chk("R6 ch1 masked timing", timing, 1'b0);
        do_reset();
        m2 = 1'b1; f2 = 1'b1;
        ticks(TS + 2);
        chk("R6 ch2 masked", shutdown, 1'b0);
        do_reset();
        m1 = 1'b1; m2 = 1'b1; f3 = 1'b1;
        ticks(TS);
        chk("R6 ch3 unmasked", shutdown, 1'b1);

        // R7: release by causing channel
        do_reset();
        f2 = 1'b1;
        ticks(TS);
        f2 = 1'b0;
        chk("R7 ch2 trip", shutdown, 1'b1);
        pulse_rel(1'b0);
        chk("R7 wrong release ch1", shutdown, 1'b1);
        pulse_rel(1'b1);
        chk("R7 ch2 release", shutdown, 1'b0);

        do_reset();
        f3 = 1'b1;
        ticks(TS);
        f3 = 1'b0;
        pulse_rel(1'b1);
        chk("R7 wrong release ch2", shutdown, 1'b1);
        pulse_rel(1'b0);
        chk("R7 ch3 release", shutdown, 1'b0);

        do_reset();
        f1 = 1'b1;
        ticks(TS);
        f1 = 1'b0;
        pulse_rel(1'b0);
        chk("R7 ch1 release", shutdown, 1'b0);

        // R8: uvlo
        do_reset();
        f1 = 1'b1;
        ticks(TS);
        chk("R8 pre", shutdown, 1'b1);
        uv = 1'b1;
        idle(1);
        chk("R8 cleared", shutdown, 1'b0);
        ticks(TS + 1);
        chk("R8 held timing", timing, 1'b0);
        chk("R8 held shutdown", shutdown, 1'b0);
        uv = 1'b0;
        ticks(TS);
        chk("R8 after release", shutdown, 1'b1);

        // R9: range drop mid-count
        do_reset();
        rl = 1'b1; f1 = 1'b1;
        ticks(TS + 2);
        chk("R9 long pre", shutdown, 1'b0);
        rl = 1'b0;
        ticks(1);
        chk("R9 overrun latch", shutdown, 1'b1);

        do_reset();
        rl = 1'b1; f1 = 1'b1;
        ticks(TS - 3);
        rl = 1'b0;
        ticks(2);
        chk("R9 below short", shutdown, 1'b0);
        ticks(1);
        chk("R9 reach short", shutdown, 1'b1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule